// File: doc/BRIEF.md
# Burst-Batched Packed Stream Buffer

This block lets a continuous stream of 16-bit samples pass through a large external memory that works as a first-in first-out store. On the way in, every four samples are combined into one 64-bit word. Packed words wait in a small local queue until a whole burst has gathered. The block then writes that burst to consecutive memory addresses. On the way out, it reads whole bursts from consecutive addresses into a second local queue, splits each word back into its four samples and presents them in the order they arrived.

The memory stands behind a simple command port. The block raises a command only in a cycle where the memory reports ready. The command carries direction, address and write data, and read data returns later, in order, with a valid strobe. Callers never handle addresses: write and read pointers advance inside the block and wrap around the memory region. Bursts of one direction are never broken up, and the direction can change only when a burst completes.

Top module: `dram_stream_buf`

## Requirements
- R1: After reset, mem_empty is 1, and mem_full, overflow, out_valid and mem_cmd_valid are all 0.
- R2: The output sample sequence equals the input sample sequence, with no loss, repetition or reordering, under any pattern of input gaps, memory stalls and output back-pressure.
- R3: In each memory word, the first sample of its group of four occupies bits [15:0], the second [31:16], the third [47:32] and the fourth [63:48].
- R4: Write addresses start at 0 after reset and increase by one per write command. Read addresses do the same independently. Both wrap modulo the memory depth.
- R5: No write command is issued until a full burst of packed words (default 8 words, i.e. 32 samples) is waiting locally.
- R6: mem_cmd_valid is high only in cycles where mem_ready is high. Neither address pointer moves while mem_ready is low, so stalls never skip or repeat an address.
- R7: Commands come in runs of exactly one burst length, all in the same direction. A read burst starts only when at least one burst is stored in memory and the read queue has room for it. When both directions are eligible, the last direction continues unless the write queue is more than half full.
- R8: mem_full is 1 when the memory region holds its depth in words, and mem_empty is 1 when it holds none. No write command is issued while the region is full.
- R9: overflow goes to 1 when a sample arrives while the local write queue is full, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample |
| out_valid | output | 1 | Output sample available |
| out_data | output | 16 | Output sample |
| out_ready | input | 1 | Consumer accepts the output sample |
| mem_cmd_valid | output | 1 | Memory command issued this cycle |
| mem_cmd_write | output | 1 | 1 = write command, 0 = read command |
| mem_cmd_addr | output | 6 | Word address of the command |
| mem_cmd_wdata | output | 64 | Packed write word |
| mem_ready | input | 1 | Memory can accept a command this cycle |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Returned word |
| mem_full | output | 1 | Memory region holds its full depth |
| mem_empty | output | 1 | Memory region holds no words |
| overflow | output | 1 | Sticky input-loss flag |

## Verification
The hardest state to reach is the one where the memory region is full, the read queue is saturated and the write queue sits exactly one sample from loss. Only then can the full flag, the write block at full and the overflow latch be seen. The stimulus reaches it by holding the output consumer off with the memory always ready and feeding a known number of samples at full rate: enough for the read queue plus the whole region, then exactly one write queue's worth more, then one sample beyond that. Random memory stalls and random consumer back-pressure over several phases drive the pointers past their wrap point while run lengths and addresses are checked against a model of the memory.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
   typedef enum logic [1:0] {
      SCH_IDLE,
      SCH_WRITE,
      SCH_READ
   } sch_state_e;

   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } dir_e;
endpackage

// File: rtl/dsb_fifo.sv
module dsb_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   localparam int AW = $clog2(DEPTH);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("dsb_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  store [DEPTH];
   logic [AW-1:0] wptr, rptr;

   always_ff @(posedge clk) begin
      if (push) store[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign dout = store[rptr];

   a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   a_r9_push_room: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/dsb_pack.sv
module dsb_pack #(
   parameter int SAMPLE_W = 16,
   parameter int WORD_W   = 64,
   localparam int LANES   = WORD_W / SAMPLE_W,
   localparam int LW      = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                word_valid,
   output logic [WORD_W-1:0]   word
);
   logic [LW-1:0] lane;

   always_ff @(posedge clk) begin
      if (!rst_n)        lane <= '0;
      else if (in_valid) lane <= lane + 1'b1;
   end

   genvar g;
   generate
      for (g = 0; g < LANES - 1; g++) begin : g_lane
         logic [SAMPLE_W-1:0] held;
         always_ff @(posedge clk) begin
            if (in_valid && (lane == LW'(g))) held <= in_data;
         end
         assign word[g*SAMPLE_W +: SAMPLE_W] = held;
      end
   endgenerate

   assign word[(LANES-1)*SAMPLE_W +: SAMPLE_W] = in_data;
   assign word_valid = in_valid && (lane == LW'(LANES - 1));

   a_r3_lane_restart: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> (lane == '0));
endmodule

// File: rtl/dsb_unpack.sv
module dsb_unpack #(
   parameter int SAMPLE_W = 16,
   parameter int WORD_W   = 64,
   localparam int LANES   = WORD_W / SAMPLE_W,
   localparam int LW      = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word_avail,
   input  logic [WORD_W-1:0]   word_in,
   output logic                word_pop,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data,
   input  logic                out_ready
);
   logic              busy;
   logic [LW-1:0]     lane;
   logic [WORD_W-1:0] word_q;
   logic              take, done;

   assign take     = busy && out_ready;
   assign done     = take && (lane == LW'(LANES - 1));
   assign word_pop = word_avail && (!busy || done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         lane <= '0;
      end else if (word_pop) begin
         busy <= 1'b1;
         lane <= '0;
      end else if (done) begin
         busy <= 1'b0;
         lane <= '0;
      end else if (take) begin
         lane <= lane + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (word_pop) word_q <= word_in;
   end

   assign out_valid = busy;
   assign out_data  = word_q[int'(lane)*SAMPLE_W +: SAMPLE_W];

   a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dsb_sched.sv
module dsb_sched
   import dsb_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int BURST      = 8,
   parameter int MEM_DEPTH  = 64,
   parameter int WBUF_DEPTH = 16,
   parameter int RBUF_DEPTH = 16,
   localparam int AW        = $clog2(MEM_DEPTH),
   localparam int WCW       = $clog2(WBUF_DEPTH + 1),
   localparam int RCW       = $clog2(RBUF_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WCW-1:0]    wbuf_count,
   input  logic [WORD_W-1:0] wbuf_head,
   output logic              wbuf_pop,
   input  logic [RCW-1:0]    rbuf_count,
   output logic              mem_cmd_valid,
   output logic              mem_cmd_write,
   output logic [AW-1:0]     mem_cmd_addr,
   output logic [WORD_W-1:0] mem_cmd_wdata,
   input  logic              mem_ready,
   input  logic              mem_rvalid,
   output logic              mem_full,
   output logic              mem_empty
);
   localparam int SCW = $clog2(MEM_DEPTH + 1);
   localparam int BCW = $clog2(BURST);
   localparam int OCW = $clog2(RBUF_DEPTH + 1);

   sch_state_e     state;
   dir_e           last_dir;
   logic [BCW-1:0] beat;
   logic [AW-1:0]  waddr, raddr;
   logic [SCW-1:0] stored;
   logic [OCW-1:0] inflight;
   logic           wr_ok, rd_ok, wr_urgent, pick_wr, issue, last_beat;
   logic           wr_issue, rd_issue;

   assign wr_ok     = (int'(wbuf_count) >= BURST) && (int'(stored) <= MEM_DEPTH - BURST);
   assign rd_ok     = (int'(stored) >= BURST) &&
                      (int'(rbuf_count) + int'(inflight) + BURST <= RBUF_DEPTH);
   assign wr_urgent = int'(wbuf_count) > (WBUF_DEPTH / 2);
   assign pick_wr   = wr_ok && (!rd_ok || wr_urgent || (last_dir == DIR_WR));
   assign last_beat = (beat == BCW'(BURST - 1));

   assign issue    = (state != SCH_IDLE) && mem_ready;
   assign wr_issue = issue && (state == SCH_WRITE);
   assign rd_issue = issue && (state == SCH_READ);

   assign mem_cmd_valid = issue;
   assign mem_cmd_write = (state == SCH_WRITE);
   assign mem_cmd_addr  = (state == SCH_WRITE) ? waddr : raddr;
   assign mem_cmd_wdata = wbuf_head;
   assign wbuf_pop      = wr_issue;

   assign mem_full  = (stored == SCW'(MEM_DEPTH));
   assign mem_empty = (stored == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SCH_IDLE;
         last_dir <= DIR_WR;
         beat     <= '0;
      end else begin
         case (state)
            SCH_IDLE: begin
               beat <= '0;
               if (pick_wr) begin
                  state    <= SCH_WRITE;
                  last_dir <= DIR_WR;
               end else if (rd_ok) begin
                  state    <= SCH_READ;
                  last_dir <= DIR_RD;
               end
            end
            default: begin
               if (mem_ready) begin
                  beat <= beat + 1'b1;
                  if (last_beat) state <= SCH_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr    <= '0;
         raddr    <= '0;
         stored   <= '0;
         inflight <= '0;
      end else begin
         if (wr_issue) waddr <= waddr + 1'b1;
         if (rd_issue) raddr <= raddr + 1'b1;
         stored   <= stored + SCW'(wr_issue) - SCW'(rd_issue);
         inflight <= inflight + OCW'(rd_issue) - OCW'(mem_rvalid);
      end
   end

   a_r6_cmd_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid |-> mem_ready);
   a_r6_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ready |=> ($stable(waddr) && $stable(raddr)));
   a_r8_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && mem_cmd_write) |-> !mem_full);
   a_r7_read_room: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rbuf_count) + int'(inflight)) <= RBUF_DEPTH);
   a_r5_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      wbuf_pop |-> (wbuf_count != '0));
endmodule

// File: rtl/dram_stream_buf.sv
module dram_stream_buf #(
   parameter int SAMPLE_W   = 16,
   parameter int WORD_W     = 64,
   parameter int BURST      = 8,
   parameter int MEM_DEPTH  = 64,
   parameter int WBUF_DEPTH = 16,
   parameter int RBUF_DEPTH = 16,
   localparam int AW        = $clog2(MEM_DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data,
   input  logic                out_ready,
   output logic                mem_cmd_valid,
   output logic                mem_cmd_write,
   output logic [AW-1:0]       mem_cmd_addr,
   output logic [WORD_W-1:0]   mem_cmd_wdata,
   input  logic                mem_ready,
   input  logic                mem_rvalid,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                mem_full,
   output logic                mem_empty,
   output logic                overflow
);
   localparam int LANES = WORD_W / SAMPLE_W;
   localparam int WCW   = $clog2(WBUF_DEPTH + 1);
   localparam int RCW   = $clog2(RBUF_DEPTH + 1);

   generate
      if ((WORD_W % SAMPLE_W) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("dram_stream_buf: WORD_W must hold a power-of-two count of samples");
      end
      if (BURST < 2 || (BURST & (BURST - 1)) != 0) begin : g_bad_burst
         $error("dram_stream_buf: BURST must be a power of two >= 2");
      end
      if ((MEM_DEPTH & (MEM_DEPTH - 1)) != 0 || MEM_DEPTH < 2 * BURST) begin : g_bad_mem
         $error("dram_stream_buf: MEM_DEPTH must be a power of two of at least two bursts");
      end
      if (WBUF_DEPTH < BURST || RBUF_DEPTH < BURST) begin : g_bad_buf
         $error("dram_stream_buf: local queues must hold at least one burst");
      end
   endgenerate

   logic              pk_valid;
   logic [WORD_W-1:0] pk_word;
   logic [WCW-1:0]    wq_count;
   logic [WORD_W-1:0] wq_head;
   logic              wq_pop, wq_push, wq_full;
   logic [RCW-1:0]    rq_count;
   logic [WORD_W-1:0] rq_head;
   logic              rq_pop;

   dsb_pack #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .word_valid(pk_valid), .word(pk_word));

   assign wq_full = (wq_count == WCW'(WBUF_DEPTH));
   assign wq_push = pk_valid && !wq_full;

   dsb_fifo #(.W(WORD_W), .DEPTH(WBUF_DEPTH)) u_wq (
      .clk(clk), .rst_n(rst_n), .push(wq_push), .din(pk_word),
      .pop(wq_pop), .dout(wq_head), .count(wq_count));

   dsb_sched #(.WORD_W(WORD_W), .BURST(BURST), .MEM_DEPTH(MEM_DEPTH),
               .WBUF_DEPTH(WBUF_DEPTH), .RBUF_DEPTH(RBUF_DEPTH)) u_sched (
      .clk(clk), .rst_n(rst_n), .wbuf_count(wq_count), .wbuf_head(wq_head),
      .wbuf_pop(wq_pop), .rbuf_count(rq_count), .mem_cmd_valid(mem_cmd_valid),
      .mem_cmd_write(mem_cmd_write), .mem_cmd_addr(mem_cmd_addr),
      .mem_cmd_wdata(mem_cmd_wdata), .mem_ready(mem_ready),
      .mem_rvalid(mem_rvalid), .mem_full(mem_full), .mem_empty(mem_empty));

   dsb_fifo #(.W(WORD_W), .DEPTH(RBUF_DEPTH)) u_rq (
      .clk(clk), .rst_n(rst_n), .push(mem_rvalid), .din(mem_rdata),
      .pop(rq_pop), .dout(rq_head), .count(rq_count));

   dsb_unpack #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .word_avail(rq_count != '0), .word_in(rq_head),
      .word_pop(rq_pop), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready));

   always_ff @(posedge clk) begin
      if (!rst_n)                   overflow <= 1'b0;
      else if (in_valid && wq_full) overflow <= 1'b1;
   end

   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(in_valid));
endmodule

// File: tb/dram_stream_buf_test.sv
module dram_stream_buf_test;
   localparam int BURST = 8;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;
   logic        out_ready = 1'b0;
   logic        mem_cmd_valid, mem_cmd_write;
   logic [5:0]  mem_cmd_addr;
   logic [63:0] mem_cmd_wdata;
   logic        mem_ready = 1'b1;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        mem_full, mem_empty, overflow;

   always #4 clk = ~clk;

   dram_stream_buf uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
      .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_full(mem_full), .mem_empty(mem_empty), .overflow(overflow));

   // columns: samples, memory ready %, output ready %, input gap %
   localparam int unsigned PHASES [6][4] = '{
      '{64, 70, 80, 0}, '{128, 50, 60, 30}, '{96, 90, 30, 10},
      '{160, 40, 90, 50}, '{32, 100, 100, 0}, '{192, 60, 50, 20}};

   int total = 0, bad = 0;
   int rdy_pct = 100, ordy_pct = 0;
   bit cmp_en = 1'b1;
   logic [15:0] seq = 16'h1000;
   logic [15:0] expq [$];
   logic [63:0] mem_model [DEPTH];
   int exp_waddr = 0, exp_raddr = 0, model_stored = 0;
   int cmd_cnt = 0, run_len = 0;
   bit run_wr = 1'b1;
   logic [63:0] first_wdata = '0;
   int first_waddr = -1;
   logic        pend_v = 1'b0;
   logic [63:0] pend_d = '0;
   logic [2:0]  pv = '0;
   logic [63:0] pd [3];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      expq.delete();
      exp_waddr = 0; exp_raddr = 0; model_stored = 0;
      cmd_cnt = 0; run_len = 0; run_wr = 1'b1; first_waddr = -1;
      pend_v = 1'b0; pv = '0;
      cmp_en = 1'b1;
      rst_n = 1'b1;
   endtask

   task automatic send(input int n, input int gap_pct, input bit track);
      int sent = 0;
      while (sent < n) begin
         @(posedge clk); #1;
         if (int'($urandom % 100) < gap_pct) begin
            in_valid = 1'b0;
         end else begin
            in_valid = 1'b1;
            in_data  = seq;
            if (track) expq.push_back(seq);
            seq = seq + 16'd1;
            sent++;
         end
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   // environment: ready signals and a read pipeline of fixed latency
   initial begin
      forever begin
         @(posedge clk); #1;
         mem_ready = (int'($urandom % 100) < rdy_pct);
         out_ready = (int'($urandom % 100) < ordy_pct);
         mem_rvalid = pv[2];
         mem_rdata  = pd[2];
         pv[2] = pv[1]; pd[2] = pd[1];
         pv[1] = pv[0]; pd[1] = pd[0];
         pv[0] = pend_v; pd[0] = pend_d;
         pend_v = 1'b0;
      end
   end

   // monitor: memory model, command rules and output order
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (mem_cmd_valid) begin
               chk(mem_ready, "R6", "command while not ready", 0, 1);
               if (run_len != 0 && (mem_cmd_write != run_wr))
                  chk((run_len % BURST) == 0, "R7", "direction change inside burst",
                      run_len % BURST, 0);
               if (run_len == 0 || mem_cmd_write != run_wr) run_len = 0;
               if (mem_cmd_write) begin
                  chk(int'(mem_cmd_addr) == exp_waddr, "R4", "write address",
                      mem_cmd_addr, exp_waddr);
                  chk(model_stored < DEPTH, "R8", "write while full", model_stored, DEPTH - 1);
                  if (first_waddr < 0) begin
                     first_waddr = int'(mem_cmd_addr);
                     first_wdata = mem_cmd_wdata;
                  end
                  mem_model[mem_cmd_addr] = mem_cmd_wdata;
                  exp_waddr = (exp_waddr + 1) % DEPTH;
                  model_stored++;
               end else begin
                  chk(int'(mem_cmd_addr) == exp_raddr, "R4", "read address",
                      mem_cmd_addr, exp_raddr);
                  if ((run_len % BURST) == 0)
                     chk(model_stored >= BURST, "R7", "read burst without stored burst",
                         model_stored, BURST);
                  pend_v = 1'b1;
                  pend_d = mem_model[mem_cmd_addr];
                  exp_raddr = (exp_raddr + 1) % DEPTH;
                  model_stored--;
               end
               run_wr = mem_cmd_write;
               run_len++;
               cmd_cnt++;
            end
            if (out_valid && out_ready && cmp_en) begin
               if (expq.size() == 0) begin
                  chk(1'b0, "R2", "unexpected output sample", out_data, 0);
               end else begin
                  logic [15:0] e;
                  e = expq.pop_front();
                  chk(out_data == e, "R2", "output sample", out_data, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rdy_pct = 100; ordy_pct = 0;
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(mem_empty == 1'b1, "R1", "mem_empty", mem_empty, 1);
      chk(mem_full == 1'b0, "R1", "mem_full", mem_full, 0);
      chk(overflow == 1'b0, "R1", "overflow", overflow, 0);
      chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
      chk(mem_cmd_valid == 1'b0, "R1", "mem_cmd_valid", mem_cmd_valid, 0);

      // R5: seven words waiting issue nothing
      seq = 16'h1000;
      send(28, 0, 1'b1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(cmd_cnt == 0, "R5", "commands before full burst", cmd_cnt, 0);
      send(4, 0, 1'b1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(cmd_cnt >= BURST, "R5", "burst after eighth word", cmd_cnt, BURST);
      // R3 word layout of the first group
      chk(first_wdata == 64'h1003_1002_1001_1000, "R3", "packed word", first_wdata,
          64'h1003_1002_1001_1000);
      chk(first_waddr == 0, "R4", "first write address", first_waddr, 0);

      ordy_pct = 100;
      for (int t = 0; t < 2000 && expq.size() != 0; t++) @(posedge clk);
      chk(expq.size() == 0, "R2", "first group drained", expq.size(), 0);

      // table of stream phases with stalls and back-pressure (R2, R4, R6, R7)
      for (int p = 0; p < 6; p++) begin
         rdy_pct  = int'(PHASES[p][1]);
         ordy_pct = int'(PHASES[p][2]);
         send(int'(PHASES[p][0]), int'(PHASES[p][3]), 1'b1);
         for (int t = 0; t < 20000 && expq.size() != 0; t++) @(posedge clk);
         chk(expq.size() == 0, "R2", "phase drained", expq.size(), 0);
      end
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(mem_empty == 1'b1, "R8", "empty after drain", mem_empty, 1);
      chk(exp_waddr == (168 + 8) % DEPTH, "R4", "write pointer wrapped", exp_waddr,
          (168 + 8) % DEPTH);

      // full region, then write queue fill, then loss (R8, R9)
      cmp_en = 1'b0;
      rdy_pct = 100; ordy_pct = 0;
      expq.delete();
      send(320, 0, 1'b0);
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(mem_full == 1'b1, "R8", "mem_full at depth", mem_full, 1);
      chk(mem_empty == 1'b0, "R8", "mem_empty at depth", mem_empty, 0);
      send(64, 0, 1'b0);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(overflow == 1'b0, "R9", "overflow with queue just full", overflow, 0);
      send(1, 0, 1'b0);
      @(negedge clk);
      chk(overflow == 1'b1, "R9", "overflow on extra sample", overflow, 1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(overflow == 1'b1, "R9", "overflow sticky", overflow, 1);

      do_reset();
      @(negedge clk);
      chk(overflow == 1'b0, "R1", "overflow cleared by reset", overflow, 0);
      chk(mem_empty == 1'b1, "R1", "empty after reset", mem_empty, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule